// File: doc/BRIEF.md
# Packed SIMD Integer Arithmetic Unit

This execution unit treats two 64-bit operands as a row of independent lanes: eight bytes, four words, two doublewords or one quadword. It adds or subtracts lane by lane and offers three overflow policies: wraparound, clamping to the signed range and clamping to the unsigned range. It also multiplies signed word lanes and keeps either the high or the low half of each 32-bit product. A multiply-add form sums the products of adjacent word pairs into doubleword results. Lane-wise compares for equality and for signed greater-than produce mask results, and four bitwise operations act on the whole quadword.

An upstream issue stage presents an opcode, a lane-size code, both operands and a valid strobe in one cycle. The unit computes the result combinationally and captures it in a register, so the result and its valid flag appear on the next clock. Operand routing, register storage and fault handling live outside this block.

Top module: `psimd_arith`

## Requirements
- R1: With opcode 0 (add) or 3 (subtract) and size code 0 (byte), 1 (word) or 2 (doubleword), every lane of the result is the wraparound sum or difference of the matching operand lanes, and no carry or borrow crosses a lane boundary.
- R2: Opcodes 1 (signed-saturating add) and 4 (signed-saturating subtract) with size code 0 or 1 clamp a lane that overflows to the most positive value (0x7F / 0x7FFF) or the most negative value (0x80 / 0x8000) of the lane, whichever lies on the side of the true result.
- R3: Opcodes 2 (unsigned-saturating add) and 5 (unsigned-saturating subtract) with size code 0 or 1 clamp a lane that overflows to all ones (add) and a lane that underflows to zero (subtract).
- R4: The saturating opcodes 1, 2, 4 and 5 with size code 2 or 3, and the opcodes 0, 3, 9 and 10 with size code 3 (quadword), give an all-zero result.
- R5: Opcode 6 gives, in each of the four word lanes, bits 31:16 of the signed product of the operand words; opcode 7 gives bits 15:0. The size code is ignored.
- R6: Opcode 8 multiplies the four signed word pairs and, for each doubleword lane k, adds the products of words 2k and 2k+1 into a 32-bit result that wraps modulo 2^32. The size code is ignored.
- R7: Opcode 9 (equal) and opcode 10 (signed greater-than), with size code 0, 1 or 2, write all ones into a lane whose condition holds and all zeros into a lane whose condition fails.
- R8: Opcodes 11 (AND), 12 (AND-NOT, i.e. the inverted first operand ANDed with the second), 13 (OR) and 14 (XOR) act on the whole 64 bits, whatever the size code.
- R9: out_valid rises on the clock edge after an edge that sees in_valid high and falls on the edge after one that sees in_valid low; the result of an operation appears in that same cycle, also for back-to-back operations.
- R10: While in_valid is low, out_result keeps its last value whatever happens on the opcode, size and operand inputs.
- R11: While rst_n is low, out_valid is low and out_result is zero.
- R12: Opcode 15 is unassigned and gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Operation presented this cycle |
| in_op | input | 4 | Opcode, codes in R1 to R12 |
| in_size | input | 2 | Lane size: 0 byte, 1 word, 2 doubleword, 3 quadword |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Registered 64-bit result |

## Verification
The bench places carries and borrows right at lane boundaries, for example 0xFF+0x01 next to a zero lane. A design that let a carry cross into the next lane would corrupt that neighbour. Saturation is tested with overflows in both directions, with true results sitting exactly on the limits and with results that just fit. A clamp that picked the wrong end, or that fired on non-overflowing results, shows up there. The multiply cases use -32768 × -32768, whose high half is 0x4000, and a multiply-add pair of them that must wrap to 0x80000000; an unsigned multiplier or a widened accumulator gives other values. The bench also covers signed compares where the operands differ in sign, size codes the unit does not support, and result holding while the strobe is low.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDSS = 4'd1,
        OP_ADDUS = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBSS = 4'd4,
        OP_SUBUS = 4'd5,
        OP_MULHI = 4'd6,
        OP_MULLO = 4'd7,
        OP_MADD  = 4'd8,
        OP_CMPEQ = 4'd9,
        OP_CMPGT = 4'd10,
        OP_AND   = 4'd11,
        OP_ANDN  = 4'd12,
        OP_OR    = 4'd13,
        OP_XOR   = 4'd14,
        OP_RSVD  = 4'd15
    } psimd_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QUAD  = 2'd3
    } psimd_size_e;

    typedef enum logic [1:0] {
        CLAMP_NONE     = 2'd0,
        CLAMP_SIGNED   = 2'd1,
        CLAMP_UNSIGNED = 2'd2
    } psimd_clamp_e;

    localparam int unsigned MUL_LANE_W = 16;
    localparam int unsigned NUM_ARITH_SIZES = 3;

endpackage

// File: rtl/psimd_addsub_bank.sv
module psimd_addsub_bank
    import psimd_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              subtract,
    input  psimd_clamp_e      clamp,
    output logic [DATA_W-1:0] lanes_out
);
    localparam int unsigned NLANES = DATA_W / LANE_W;
    localparam int unsigned MSB    = LANE_W - 1;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb, raw, sel;
        logic [LANE_W:0]   ext;
        logic              sgn_ovf, uns_ovf;

        assign la  = opa[g*LANE_W +: LANE_W];
        assign lb  = opb[g*LANE_W +: LANE_W];
        assign ext = subtract ? ({1'b0, la} - {1'b0, lb})
                              : ({1'b0, la} + {1'b0, lb});
        assign raw = ext[LANE_W-1:0];
        assign uns_ovf = ext[LANE_W];
        assign sgn_ovf = subtract ? ((la[MSB] != lb[MSB]) && (raw[MSB] != la[MSB]))
                                  : ((la[MSB] == lb[MSB]) && (raw[MSB] != la[MSB]));

        always_comb begin
            sel = raw;
            case (clamp)
                CLAMP_SIGNED: begin
                    if (sgn_ovf) begin
                        sel = la[MSB] ? {1'b1, {(LANE_W-1){1'b0}}}
                                      : {1'b0, {(LANE_W-1){1'b1}}};
                    end
                end
                CLAMP_UNSIGNED: begin
                    if (uns_ovf) begin
                        sel = subtract ? {LANE_W{1'b0}} : {LANE_W{1'b1}};
                    end
                end
                default: sel = raw;
            endcase
        end

        assign lanes_out[g*LANE_W +: LANE_W] = sel;
    end

endmodule

// File: rtl/psimd_cmp_bank.sv
module psimd_cmp_bank #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] eq_mask,
    output logic [DATA_W-1:0] gt_mask
);
    localparam int unsigned NLANES = DATA_W / LANE_W;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb;
        assign la = opa[g*LANE_W +: LANE_W];
        assign lb = opb[g*LANE_W +: LANE_W];
        assign eq_mask[g*LANE_W +: LANE_W] = {LANE_W{la == lb}};
        assign gt_mask[g*LANE_W +: LANE_W] = {LANE_W{$signed(la) > $signed(lb)}};
    end

endmodule

// File: rtl/psimd_mul_unit.sv
module psimd_mul_unit
    import psimd_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] prod_hi,
    output logic [DATA_W-1:0] prod_lo,
    output logic [DATA_W-1:0] pair_sum
);
    localparam int unsigned W      = MUL_LANE_W;
    localparam int unsigned PW     = 2 * W;
    localparam int unsigned NWORDS = DATA_W / W;
    localparam int unsigned NPAIRS = NWORDS / 2;

    logic [PW-1:0] prod [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic signed [W-1:0]  sa, sb;
        logic signed [PW-1:0] p;
        assign sa = opa[g*W +: W];
        assign sb = opb[g*W +: W];
        assign p  = sa * sb;
        assign prod[g] = p;
        assign prod_hi[g*W +: W] = p[PW-1:W];
        assign prod_lo[g*W +: W] = p[W-1:0];
    end

    for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
        assign pair_sum[k*PW +: PW] = prod[2*k] + prod[2*k+1];
    end

endmodule

// File: rtl/psimd_arith.sv
module psimd_arith
    import psimd_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned MIN_LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int unsigned NSZ = NUM_ARITH_SIZES;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } out_state_t;

    out_state_t state_d, state_q;

    psimd_op_e    op;
    psimd_size_e  size;
    logic         subtract;
    psimd_clamp_e clamp;
    logic         saturating;

    logic [DATA_W-1:0] as_res [NSZ];
    logic [DATA_W-1:0] eq_res [NSZ];
    logic [DATA_W-1:0] gt_res [NSZ];
    logic [DATA_W-1:0] mul_hi, mul_lo, mul_pair;
    logic [DATA_W-1:0] result_sel;

    assign op   = psimd_op_e'(in_op);
    assign size = psimd_size_e'(in_size);

    always_comb begin
        subtract = 1'b0;
        clamp    = CLAMP_NONE;
        case (op)
            OP_ADDSS: clamp = CLAMP_SIGNED;
            OP_ADDUS: clamp = CLAMP_UNSIGNED;
            OP_SUB:   subtract = 1'b1;
            OP_SUBSS: begin subtract = 1'b1; clamp = CLAMP_SIGNED;   end
            OP_SUBUS: begin subtract = 1'b1; clamp = CLAMP_UNSIGNED; end
            default: ;
        endcase
    end

    assign saturating = (clamp != CLAMP_NONE);

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        psimd_addsub_bank #(
            .DATA_W (DATA_W),
            .LANE_W (MIN_LANE_W << s)
        ) u_addsub (
            .opa       (in_a),
            .opb       (in_b),
            .subtract  (subtract),
            .clamp     (clamp),
            .lanes_out (as_res[s])
        );

        psimd_cmp_bank #(
            .DATA_W (DATA_W),
            .LANE_W (MIN_LANE_W << s)
        ) u_cmp (
            .opa     (in_a),
            .opb     (in_b),
            .eq_mask (eq_res[s]),
            .gt_mask (gt_res[s])
        );
    end

    psimd_mul_unit #(
        .DATA_W (DATA_W)
    ) u_mul (
        .opa      (in_a),
        .opb      (in_b),
        .prod_hi  (mul_hi),
        .prod_lo  (mul_lo),
        .pair_sum (mul_pair)
    );

    always_comb begin
        result_sel = '0;
        case (op)
            OP_ADD, OP_SUB, OP_ADDSS, OP_ADDUS, OP_SUBSS, OP_SUBUS: begin
                case (size)
                    SZ_BYTE:  result_sel = as_res[0];
                    SZ_WORD:  result_sel = as_res[1];
                    SZ_DWORD: result_sel = saturating ? '0 : as_res[2];
                    default:  result_sel = '0;
                endcase
            end
            OP_CMPEQ, OP_CMPGT: begin
                case (size)
                    SZ_BYTE:  result_sel = (op == OP_CMPEQ) ? eq_res[0] : gt_res[0];
                    SZ_WORD:  result_sel = (op == OP_CMPEQ) ? eq_res[1] : gt_res[1];
                    SZ_DWORD: result_sel = (op == OP_CMPEQ) ? eq_res[2] : gt_res[2];
                    default:  result_sel = '0;
                endcase
            end
            OP_MULHI: result_sel = mul_hi;
            OP_MULLO: result_sel = mul_lo;
            OP_MADD:  result_sel = mul_pair;
            OP_AND:   result_sel = in_a & in_b;
            OP_ANDN:  result_sel = ~in_a & in_b;
            OP_OR:    result_sel = in_a | in_b;
            OP_XOR:   result_sel = in_a ^ in_b;
            default:  result_sel = '0;
        endcase
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = result_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.vld;
    assign out_result = state_q.res;

endmodule

// File: rtl/psimd_arith_chk.sv
module psimd_arith_chk
    import psimd_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_op,
    input logic [1:0]        in_size,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    // R8
    and_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_AND) |=> out_result == $past(in_a & in_b));

    // R8
    xor_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_XOR) |=> out_result == $past(in_a ^ in_b));

    // R4
    wide_sat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size[1] &&
         (in_op == OP_ADDSS || in_op == OP_ADDUS || in_op == OP_SUBSS || in_op == OP_SUBUS))
        |=> out_result == '0);

    // R12
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_RSVD) |=> out_result == '0);

    // R7
    eq_same_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CMPEQ && in_size == SZ_BYTE && in_a == in_b)
        |=> &out_result);

endmodule

bind psimd_arith psimd_arith_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_size    (in_size),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/psimd_arith_tb.sv
module psimd_arith_tb_top;
    import psimd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = 4'd0;
    logic [1:0]  in_size = 2'd0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    psimd_arith dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_size    (in_size),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Present one operation, then check valid and result one clock later.
    task automatic run_op(input string tag, input logic [3:0] op, input logic [1:0] sz,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_size = sz; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, out_result, exp);
    endtask

    task automatic t_reset();
        check("R11 reset valid", {63'd0, out_valid}, 64'd0);
        check("R11 reset result", out_result, 64'd0);
    endtask

    task automatic t_wrap();
        run_op("R1 byte add", OP_ADD, SZ_BYTE, 64'h00FF_7F80_0102_FF01,
               64'h0001_0180_0304_0101, 64'h0000_8000_0406_0002);
        run_op("R1 word add", OP_ADD, SZ_WORD, 64'h00FF_7F80_0102_FF01,
               64'h0001_0180_0304_0101, 64'h0100_8100_0406_0002);
        run_op("R1 dword add", OP_ADD, SZ_DWORD, 64'h00FF_7F80_0102_FF01,
               64'h0001_0180_0304_0101, 64'h0100_8100_0407_0002);
        run_op("R1 byte sub", OP_SUB, SZ_BYTE, 64'h0, 64'h1, 64'h0000_0000_0000_00FF);
        run_op("R1 dword sub", OP_SUB, SZ_DWORD, 64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_signed_sat();
        run_op("R2 byte sadd", OP_ADDSS, SZ_BYTE, 64'h7F80_10F0_7F80_0001,
               64'h01FF_20F0_7F80_00FF, 64'h7F80_30E0_7F80_0000);
        run_op("R2 word ssub", OP_SUBSS, SZ_WORD, 64'h8000_7FFF_0005_FFFF,
               64'h0001_FFFF_0007_0001, 64'h8000_7FFF_FFFE_FFFE);
    endtask

    task automatic t_unsigned_sat();
        run_op("R3 byte uadd", OP_ADDUS, SZ_BYTE, 64'hFFF0_0180_0000_0000,
               64'h0120_0280_0000_0000, 64'hFFFF_03FF_0000_0000);
        run_op("R3 word usub", OP_SUBUS, SZ_WORD, 64'h0001_8000_0010_FFFF,
               64'h0002_7FFF_0010_0001, 64'h0000_0001_0000_FFFE);
    endtask

    task automatic t_unsupported();
        run_op("R4 dword sadd", OP_ADDSS, SZ_DWORD, 64'h7FFF_FFFF_0000_0001,
               64'h0000_0001_0000_0001, 64'h0);
        run_op("R4 quad uadd", OP_ADDUS, SZ_QUAD, 64'h1, 64'h1, 64'h0);
        run_op("R4 quad add", OP_ADD, SZ_QUAD, 64'h1, 64'h1, 64'h0);
        run_op("R4 quad cmpeq", OP_CMPEQ, SZ_QUAD, 64'h5, 64'h5, 64'h0);
        run_op("R12 reserved op", OP_RSVD, SZ_BYTE, 64'hFFFF, 64'hFFFF, 64'h0);
    endtask

    task automatic t_mul();
        run_op("R5 mul high", OP_MULHI, SZ_BYTE, 64'h7FFF_8000_FFFF_0100,
               64'h7FFF_8000_0002_0100, 64'h3FFF_4000_FFFF_0001);
        run_op("R5 mul low", OP_MULLO, SZ_QUAD, 64'h7FFF_8000_FFFF_0100,
               64'h7FFF_8000_0002_0100, 64'h0001_0000_FFFE_0000);
        run_op("R6 mul add pairs", OP_MADD, SZ_WORD, 64'h8000_8000_0003_FFFF,
               64'h8000_8000_0004_0002, 64'h8000_0000_0000_000A);
    endtask

    task automatic t_compare();
        run_op("R7 byte eq", OP_CMPEQ, SZ_BYTE, 64'h0102_0304_0506_0708,
               64'h0102_0000_0506_0000, 64'hFFFF_0000_FFFF_0000);
        run_op("R7 byte gt", OP_CMPGT, SZ_BYTE, 64'h807F_00FF_0105_0500,
               64'h7F80_FF00_0005_0600, 64'h00FF_FF00_FF00_0000);
        run_op("R7 word gt", OP_CMPGT, SZ_WORD, 64'h8000_0001_7FFF_FFFF,
               64'h0000_0000_8000_FFFE, 64'h0000_FFFF_FFFF_FFFF);
        run_op("R7 dword eq", OP_CMPEQ, SZ_DWORD, 64'h1234_5678_9ABC_DEF0,
               64'h1234_5678_9ABC_DEF1, 64'hFFFF_FFFF_0000_0000);
    endtask

    task automatic t_logic();
        run_op("R8 and", OP_AND, SZ_BYTE, 64'hF0F0_FF00_AAAA_1234,
               64'h0FF0_F0F0_5555_FFFF, 64'h00F0_F000_0000_1234);
        run_op("R8 andn", OP_ANDN, SZ_WORD, 64'hF0F0_FF00_AAAA_1234,
               64'h0FF0_F0F0_5555_FFFF, 64'h0F00_00F0_5555_EDCB);
        run_op("R8 or", OP_OR, SZ_DWORD, 64'hF0F0_FF00_AAAA_1234,
               64'h0FF0_F0F0_5555_FFFF, 64'hFFF0_FFF0_FFFF_FFFF);
        run_op("R8 xor", OP_XOR, SZ_QUAD, 64'hF0F0_FF00_AAAA_1234,
               64'h0FF0_F0F0_5555_FFFF, 64'hFF00_0FF0_FFFF_EDCB);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_valid = 1'b1; in_op = OP_ADD; in_size = SZ_BYTE;
        in_a = 64'h0101_0101_0101_0101; in_b = 64'h0101_0101_0101_0101;
        @(negedge clk);
        check("R9 first of pair valid", {63'd0, out_valid}, 64'd1);
        check("R9 first of pair result", out_result, 64'h0202_0202_0202_0202);
        in_op = OP_XOR; in_a = 64'hFFFF_0000_FFFF_0000; in_b = 64'h00FF_00FF_00FF_00FF;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second of pair valid", {63'd0, out_valid}, 64'd1);
        check("R9 second of pair result", out_result, 64'hFF00_00FF_FF00_00FF);
    endtask

    task automatic t_hold();
        run_op("R10 setup", OP_OR, SZ_BYTE, 64'h1234_0000_0000_0000,
               64'h0000_0000_0000_5678, 64'h1234_0000_0000_5678);
        for (int i = 0; i < 4; i++) begin
            in_op = OP_RSVD; in_a = 64'hDEAD_BEEF_0000_0000 + 64'(i); in_b = ~in_a;
            @(negedge clk);
            check("R9 valid low when idle", {63'd0, out_valid}, 64'd0);
            check("R10 result held", out_result, 64'h1234_0000_0000_5678);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_wrap();
        t_signed_sat();
        t_unsigned_sat();
        t_unsupported();
        t_mul();
        t_compare();
        t_logic();
        t_back_to_back();
        t_hold();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        done = 1'b1;
        finish_sim();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_sim();
        end
    end

endmodule